// File: doc/BRIEF.md
# Eight-Input ADC Control and Status Front End

This block sits between a 32-bit register bus and an eight-input 10-bit successive-approximation converter. Software picks a channel and asks for a conversion through a configuration register, and switches the converter on and off through a power register. The block times the start of the converter: it counts a settling interval after power-up, and a start request that arrives early is kept and issued once that interval ends.

When the converter reports done, the block captures the 10-bit sample and the channel that was actually converted. It then raises an end-of-conversion flag and advances a completion counter. Software can compare the captured channel with the one it asked for. In continuous mode the start request stays set, so conversions run back to back until software clears it.

Top module: `adc_ctl_regs`

## Requirements
- R1: Registers are selected by byte address: configuration 0x00, result 0x04, end-of-conversion 0x08, sampled channel 0x0C, power 0x10, debug 0x14, completion count 0x20. Any other address reads as zero.
- R2: The configuration register holds the channel in bits [2:0], the start request in bit 4 and single-shot mode in bit 5, and reads back these fields.
- R3: After bit 0 of the power register is written to 1, `cnv_start` stays low until SETTLE (default 6) clocks have passed. With a start already pending, the first `cnv_start` pulse appears on the 7th rising edge after the edge that captured the power write.
- R4: A start requested while the converter is off or settling is held, not dropped. `cnv_start` is never high while `cnv_pwr` is low, and it lasts exactly one clock.
- R5: On `cnv_done` during a conversion, the result register returns the 10-bit sample in bits [9:0] with bits [31:10] zero. The sampled-channel register returns in bits [2:0] the channel that was converted.
- R6: Bit 0 of the end-of-conversion register is set by a completed conversion. It is cleared when the next start is issued or when the power bit is written to 0.
- R7: In single-shot mode (bit 5 = 1) the start bit clears when the conversion is issued. In continuous mode (bit 5 = 0) it stays set and conversions repeat.
- R8: While a conversion is outstanding, `cnv_chan` holds its value and writes to the configuration channel field are ignored. The start and mode bits are still written. When the block is idle, channel writes take effect.
- R9: The completion count at 0x20 increments by one for each completed conversion and is zero after reset.
- R10: A `cnv_done` pulse with no conversion outstanding changes neither the result, the flag nor the count.
- R11: The debug register shows the converter-side controls: bit 0 power, bit 1 start, bits [6:4] channel, bit 8 conversion outstanding.
- R12: After reset every register reads zero and `cnv_pwr`, `cnv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and converter control |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cnv_pwr | output | 1 | Converter power enable |
| cnv_start | output | 1 | One-clock conversion start pulse |
| cnv_chan | output | 3 | Channel presented to the converter |
| cnv_done | input | 1 | Conversion complete pulse |
| cnv_data | input | 10 | Sample, valid with `cnv_done` |

## Verification
The bench issues a start before power-up and checks `cnv_start` on every clock of the settling window. A block that ignored the window would pulse too early, and one that dropped the early request would never pulse. It rewrites the channel in the middle of a conversion: a design that let that write through would tag the result with the wrong channel. It also sends a stray done while idle, which a careless design would count as a result. Finally it powers down with the flag set and runs continuous mode, which exposes a stale flag or a start bit that clears when it should not.

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs #(
  parameter int CH_W   = 3,
  parameter int RES_W  = 10,
  parameter int SETTLE = 6,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cnv_pwr,
  output logic              cnv_start,
  output logic [CH_W-1:0]   cnv_chan,
  input  logic              cnv_done,
  input  logic [RES_W-1:0]  cnv_data
);
  localparam int SET_W     = $clog2(SETTLE + 1);
  localparam int WA_W      = ADDR_W - 2;
  localparam int START_BIT = 4;
  localparam int MODE_BIT  = 5;
  localparam logic [WA_W-1:0] A_CFG  = WA_W'(0);
  localparam logic [WA_W-1:0] A_RES  = WA_W'(1);
  localparam logic [WA_W-1:0] A_EOC  = WA_W'(2);
  localparam logic [WA_W-1:0] A_SAMP = WA_W'(3);
  localparam logic [WA_W-1:0] A_PWR  = WA_W'(4);
  localparam logic [WA_W-1:0] A_DBG  = WA_W'(5);
  localparam logic [WA_W-1:0] A_CNT  = WA_W'(8);

  logic [CH_W-1:0]  cfg_chan, act_chan, samp_q;
  logic             cfg_start, cfg_single;
  logic             pwr_q, start_q, busy_q, eoc_q;
  logic [SET_W-1:0] settle_q;
  logic [RES_W-1:0] res_q;
  logic [CNT_W-1:0] cnt_q;

  wire [WA_W-1:0] waddr   = bus_addr[ADDR_W-1:2];
  wire            aligned = (bus_addr[1:0] == 2'b00);
  wire            wr_cfg  = bus_wr & aligned & (waddr == A_CFG);
  wire            wr_pwr  = bus_wr & aligned & (waddr == A_PWR);
  wire            pwr_off = wr_pwr & ~bus_wdata[0];
  wire            settled = (settle_q == SET_W'(SETTLE));
  wire            issue   = cfg_start & pwr_q & settled & ~busy_q;
  wire            finish  = busy_q & cnv_done & pwr_q;

  logic unused_ok;
  assign unused_ok = ^bus_wdata;

  assign cnv_pwr   = pwr_q;
  assign cnv_start = start_q;
  assign cnv_chan  = act_chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_chan   <= '0;
      cfg_start  <= 1'b0;
      cfg_single <= 1'b0;
      act_chan   <= '0;
      samp_q     <= '0;
      pwr_q      <= 1'b0;
      start_q    <= 1'b0;
      busy_q     <= 1'b0;
      eoc_q      <= 1'b0;
      settle_q   <= '0;
      res_q      <= '0;
      cnt_q      <= '0;
    end else begin
      start_q <= issue & ~pwr_off;

      if (!pwr_q)        settle_q <= '0;
      else if (!settled) settle_q <= settle_q + 1'b1;

      if (issue) begin
        busy_q   <= 1'b1;
        act_chan <= cfg_chan;
        eoc_q    <= 1'b0;
        if (cfg_single) cfg_start <= 1'b0;
      end

      if (finish) begin
        busy_q <= 1'b0;
        res_q  <= cnv_data;
        samp_q <= act_chan;
        eoc_q  <= 1'b1;
        cnt_q  <= cnt_q + 1'b1;
      end

      if (wr_cfg) begin
        cfg_start  <= bus_wdata[START_BIT];
        cfg_single <= bus_wdata[MODE_BIT];
        if (!busy_q && !issue) cfg_chan <= bus_wdata[CH_W-1:0];
      end

      if (wr_pwr) pwr_q <= bus_wdata[0];

      if (pwr_off) begin
        busy_q   <= 1'b0;
        eoc_q    <= 1'b0;
        settle_q <= '0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (waddr)
        A_CFG:   bus_rdata = 32'(cfg_chan) | (32'(cfg_start) << START_BIT)
                           | (32'(cfg_single) << MODE_BIT);
        A_RES:   bus_rdata = 32'(res_q);
        A_EOC:   bus_rdata = 32'(eoc_q);
        A_SAMP:  bus_rdata = 32'(samp_q);
        A_PWR:   bus_rdata = 32'(pwr_q);
        A_DBG:   bus_rdata = 32'(pwr_q) | (32'(start_q) << 1)
                           | (32'(act_chan) << 4) | (32'(busy_q) << 8);
        A_CNT:   bus_rdata = 32'(cnt_q);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_ctl_regs_chk.sv
module adc_ctl_regs_chk #(
  parameter int SETTLE = 6,
  parameter int CH_W   = 3,
  parameter int CNT_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv_pwr,
  input logic             cnv_start,
  input logic [CH_W-1:0]  cnv_chan,
  input logic             cnv_done,
  input logic             busy,
  input logic             eoc,
  input logic [CNT_W-1:0] cnt
);
  localparam int CK_W = $clog2(SETTLE + 2);
  logic [CK_W-1:0] on_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !cnv_pwr) on_cnt <= '0;
    else if (on_cnt != CK_W'(SETTLE + 1)) on_cnt <= on_cnt + 1'b1;
  end

  p_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> on_cnt == CK_W'(SETTLE + 1));

  p_start_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> cnv_pwr);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start);

  p_eoc_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_pwr |-> !eoc);

  p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnv_start) |-> $stable(cnv_chan));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnv_done && cnv_pwr) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cnv_done) |=> $stable(cnt));
endmodule

bind adc_ctl_regs adc_ctl_regs_chk #(.SETTLE(SETTLE), .CH_W(CH_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_pwr(cnv_pwr), .cnv_start(cnv_start),
  .cnv_chan(cnv_chan), .cnv_done(cnv_done), .busy(busy_q), .eoc(eoc_q), .cnt(cnt_q)
);

// File: tb/tb_adc_ctl_regs.sv
module tb_adc_ctl_regs;
  localparam int LAT = 5;
  localparam logic [5:0] A_CFG = 6'h00, A_RES = 6'h04, A_EOC = 6'h08, A_SAMP = 6'h0C,
                         A_PWR = 6'h10, A_DBG = 6'h14, A_CNT = 6'h20;
  localparam logic [12:0] VEC [0:7] = '{
    {3'd0, 10'd17}, {3'd5, 10'd2}, {3'd7, 10'd232}, {3'd1, 10'd900},
    {3'd3, 10'd0},  {3'd6, 10'd300}, {3'd2, 10'd44}, {3'd4, 10'd123}};

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic cnv_pwr, cnv_start, cnv_done;
  logic [2:0] cnv_chan;
  logic [9:0] cnv_data, stub_data;
  logic stub_done, idle_done = 0;
  int stub_off = 0, lat = 0;
  int n_tests = 0, n_fail = 0, exp_cnt = 0;
  logic [31:0] d, a, b;
  logic [2:0] ch;

  always #10 clk = ~clk;

  adc_ctl_regs dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnv_pwr(cnv_pwr), .cnv_start(cnv_start),
    .cnv_chan(cnv_chan), .cnv_done(cnv_done), .cnv_data(cnv_data));

  always @(posedge clk) begin
    if (!rst_n) begin lat <= 0; stub_done <= 0; stub_data <= 0; end
    else begin
      if (cnv_start) lat <= LAT; else if (lat != 0) lat <= lat - 1;
      stub_done <= (lat == 1);
      stub_data <= 10'((int'(cnv_chan) * 113 + stub_off) % 1024);
    end
  end
  assign cnv_done = stub_done | idle_done;
  assign cnv_data = idle_done ? 10'h155 : stub_data;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] ad, logic [31:0] v);
    @(negedge clk); bus_addr = ad; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] ad, output logic [31:0] v);
    @(negedge clk); bus_addr = ad; #1 v = bus_rdata;
  endtask

  task automatic wait_eoc();
    logic [31:0] e;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      rd(A_EOC, e);
      if (e[0]) break;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    // R12 reset state
    rd(A_CFG, d); chk("R12 cfg", d, 0);
    rd(A_RES, d); chk("R12 res", d, 0);
    rd(A_EOC, d); chk("R12 eoc", d, 0);
    rd(A_CNT, d); chk("R12 cnt", d, 0);
    chk("R12 pwr pin", {30'd0, cnv_pwr, cnv_start}, 0);

    // R4 pending start while unpowered, R3 settling window
    stub_off = 10;
    wr(A_CFG, 32'h31);
    rd(A_CFG, d); chk("R2 cfg readback", d, 32'h31);
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (cnv_start) chk("R4 start while off", 1, 0); end
    wr(A_PWR, 1);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk($sformatf("R3 settle edge %0d", k), cnv_start, k == 7);
    end
    wait_eoc(); exp_cnt++;
    rd(A_RES, d);  chk("R5 first result", d, 123);
    rd(A_SAMP, d); chk("R5 first channel", d, 1);
    rd(A_CFG, d);  chk("R7 start self-clear", d, 32'h21);
    rd(A_PWR, d);  chk("R1 pwr readback", d, 1);

    // vector table: one conversion per entry
    for (int i = 0; i < 8; i++) begin
      ch = VEC[i][12:10];
      stub_off = int'(VEC[i][9:0]);
      wr(A_CFG, 32'h30 | 32'(ch));
      wait_eoc(); exp_cnt++;
      rd(A_RES, d);  chk("R5 result", d, 32'((int'(ch) * 113 + stub_off) % 1024));
      rd(A_SAMP, d); chk("R5 sampled channel", d, 32'(ch));
      rd(A_CNT, d);  chk("R9 count", d, 32'(exp_cnt));
    end

    // R6 flag clears on new start
    stub_off = 0;
    wr(A_CFG, 32'h33);
    rd(A_EOC, d); chk("R6 eoc clear on start", d, 0);
    wait_eoc(); exp_cnt++;

    // R8 channel write during conversion ignored, R11 debug
    wr(A_CFG, 32'h32);
    repeat (1) @(negedge clk);
    wr(A_CFG, 32'h26);
    rd(A_DBG, d); chk("R11 debug busy", d, 32'h121);
    wait_eoc(); exp_cnt++;
    rd(A_SAMP, d); chk("R8 sampled stays", d, 2);
    rd(A_RES, d);  chk("R8 result of ch2", d, 226);
    rd(A_CFG, d);  chk("R8 cfg chan held", d, 32'h22);
    wr(A_CFG, 32'h26);
    rd(A_CFG, d);  chk("R8 idle write taken", d, 32'h26);

    // R10 done while idle
    idle_done = 1; @(negedge clk); idle_done = 0;
    rd(A_CNT, d); chk("R10 count unchanged", d, 32'(exp_cnt));
    rd(A_RES, d); chk("R10 result unchanged", d, 226);
    rd(A_EOC, d); chk("R10 eoc unchanged", d, 1);

    // R7 continuous mode
    wr(A_CFG, 32'h13);
    rd(A_CNT, a);
    repeat (40) @(negedge clk);
    rd(A_CNT, b);
    chk("R7 continuous repeats", 32'(b - a >= 3), 1);
    rd(A_CFG, d); chk("R7 start bit kept", d, 32'h13);
    wr(A_CFG, 32'h23);
    repeat (20) @(negedge clk);
    rd(A_CNT, a);
    repeat (20) @(negedge clk);
    rd(A_CNT, b); chk("R7 stops when cleared", b, a);
    rd(A_SAMP, d); chk("R5 continuous channel", d, 3);

    // R6 power down clears flag
    rd(A_EOC, d); chk("R6 eoc set before off", d, 1);
    wr(A_PWR, 0);
    rd(A_EOC, d); chk("R6 eoc clear on power off", d, 0);
    rd(A_DBG, d); chk("R11 debug power bit", d & 32'h103, 0);

    // R1 unmapped
    rd(6'h18, d); chk("R1 unmapped", d, 0);
    rd(6'h06, d); chk("R1 misaligned", d, 0);

    // R9/R12 reset clears count
    @(negedge clk); rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    rd(A_CNT, d); chk("R9 count reset", d, 0);
    rd(A_SAMP, d); chk("R12 sampled reset", d, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule